// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor Core

This core runs one 32-bit instruction per clock cycle. Each cycle it presents its program counter to an external instruction memory and decodes the returned word. It reads two operands from a 32 x 32 register file, computes with its main ALU and, in the same cycle, drives an external data memory. The register write and the program counter update commit together on the next rising edge.

The recognised instructions are:

- unsigned add and unsigned subtract (register forms);
- OR with a zero-extended immediate;
- word load and word store at a register plus a sign-extended offset;
- branch when two registers are equal.

Every other encoding is treated as a no-operation. A dedicated incrementer forms PC+4 and a second adder forms the branch target, so the main ALU is used only for the instruction's own operation. The equality test for the branch is the ALU zero flag after a subtraction.

Both memory ports are plain single-cycle interfaces with no handshake and no back-pressure. A read must return its word combinationally within the same cycle. The store strobe is a one-cycle write request that the memory must accept at the next rising edge. The core never stalls, so the instruction flow cannot be throttled from outside.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0. While reset is high, `dmem_we` stays 0 and no register is written.
- R2: Each cycle, `imem_addr` equals the program counter. Every instruction other than a taken branch advances it by 4 at the next rising edge.
- R3: Opcode bits [31:26]=000000 with function bits [5:0]=100001 writes rs+rt (mod 2^32) into register rd. The fields are rs=[25:21], rt=[20:16] and rd=[15:11].
- R4: Opcode 000000 with function 100011 writes rs−rt (mod 2^32) into register rd.
- R5: Opcode 001101 writes rs OR {16'h0000, imm[15:0]} into register rt. The immediate is zero-extended.
- R6: Opcode 100011 drives `dmem_addr` = rs + sign-extended imm. The word returned on `dmem_rdata` is written into register rt.
- R7: Opcode 101011 drives `dmem_addr` = rs + sign-extended imm and `dmem_wdata` = rt, with `dmem_we` = 1 for that cycle only.
- R8: Opcode 000100 compares rs with rt. If they are equal, the next PC is PC+4+(sign-extended imm << 2), which may point forward or backward. If they differ, the next PC is PC+4.
- R9: Register 0 reads as zero and ignores writes.
- R10: Any other opcode, or opcode 000000 with any other function code, writes no register, does not assert `dmem_we`, and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction to fetch (the PC) |
| imem_rdata | input | 32 | Instruction word, returned combinationally |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, committed at the next rising edge |
| dmem_rdata | input | 32 | Load data, returned combinationally |

## Verification
All data memory outputs (`dmem_addr`, `dmem_wdata`, `dmem_we`) are combinational from the current instruction. They are therefore due in the same cycle the instruction sits on `imem_rdata`. A register write becomes visible to the reads of the following cycle, and the PC for the next instruction appears one rising edge later.

The bench runs an instruction-level model of the program ahead of time and queues one expected record per cycle. The monitor compares one record per clock period, 1 ns after the falling edge, so every combinational result has settled and the edge's commits have already happened. Register contents are made visible by storing them and comparing the store's address and data.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

  localparam int unsigned INSN_W = 32;
  localparam int unsigned IMM_W  = 16;
  localparam int unsigned RIDX_W = 5;

  // ALU operation select; the encoding matters to any external ALU driver
  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  localparam logic [5:0] OPC_REG   = 6'b000000;
  localparam logic [5:0] OPC_ORIMM = 6'b001101;
  localparam logic [5:0] OPC_LOAD  = 6'b100011;
  localparam logic [5:0] OPC_STORE = 6'b101011;
  localparam logic [5:0] OPC_BREQ  = 6'b000100;
  localparam logic [5:0] FN_ADDU   = 6'b100001;
  localparam logic [5:0] FN_SUBU   = 6'b100011;

  typedef struct packed {
    logic    reg_we;
    logic    dst_is_rd;
    logic    b_from_imm;
    logic    imm_zero_ext;
    logic    mem_we;
    logic    load_to_reg;
    logic    is_branch;
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/sc_core_decode.sv
module sc_core_decode
  import sc_core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '{reg_we: 1'b0, dst_is_rd: 1'b0, b_from_imm: 1'b0,
             imm_zero_ext: 1'b0, mem_we: 1'b0, load_to_reg: 1'b0,
             is_branch: 1'b0, alu_op: ALU_ADD};
    unique case (opcode)
      OPC_REG: begin
        ctrl.dst_is_rd = 1'b1;
        if (funct == FN_ADDU) begin
          ctrl.reg_we = 1'b1;
          ctrl.alu_op = ALU_ADD;
        end else if (funct == FN_SUBU) begin
          ctrl.reg_we = 1'b1;
          ctrl.alu_op = ALU_SUB;
        end
      end
      OPC_ORIMM: begin
        ctrl.reg_we       = 1'b1;
        ctrl.b_from_imm   = 1'b1;
        ctrl.imm_zero_ext = 1'b1;
        ctrl.alu_op       = ALU_OR;
      end
      OPC_LOAD: begin
        ctrl.reg_we      = 1'b1;
        ctrl.b_from_imm  = 1'b1;
        ctrl.load_to_reg = 1'b1;
        ctrl.alu_op      = ALU_ADD;
      end
      OPC_STORE: begin
        ctrl.mem_we     = 1'b1;
        ctrl.b_from_imm = 1'b1;
        ctrl.alu_op     = ALU_ADD;
      end
      OPC_BREQ: begin
        ctrl.is_branch = 1'b1;
        ctrl.alu_op    = ALU_SUB;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sc_core_regfile.sv
module sc_core_regfile #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREGS  = 32,
  localparam int unsigned IDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  raddr_a,
  input  logic [IDX_W-1:0]  raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata
);

  // Entry 0 is never stored; it is tied to zero on both read paths.
  logic [DATA_W-1:0] regs [1:NREGS-1];

  for (genvar g = 1; g < NREGS; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (we && waddr == IDX_W'(g)) regs[g] <= wdata;
    end
  end

  always_comb rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  always_comb rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];

endmodule

// File: rtl/sc_core_alu.sv
module sc_core_alu
  import sc_core_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);

  logic [W-1:0] diff;

  always_comb begin
    diff = a - b;
    unique case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = diff;
      // signed compare: on differing signs the negative operand is smaller
      ALU_SLT: y = W'((a[W-1] ^ b[W-1]) ? a[W-1] : diff[W-1]);
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/sc_core_nextpc.sv
module sc_core_nextpc #(
  parameter int unsigned W     = 32,
  parameter int unsigned IMM_W = 16
) (
  input  logic [W-1:0]     pc,
  input  logic [IMM_W-1:0] offset,
  input  logic             take,
  output logic [W-1:0]     pc_next
);

  logic [W-1:0] pc_inc;
  logic [W-1:0] disp;
  logic [W-1:0] target;

  always_comb begin
    pc_inc  = pc + W'(4);
    disp    = {{(W-IMM_W-2){offset[IMM_W-1]}}, offset, 2'b00};
    target  = pc_inc + disp;
    pc_next = take ? target : pc_inc;
  end

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned NREGS = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [XLEN-1:0] imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);

  localparam int unsigned IDX_W = $clog2(NREGS);

  logic [XLEN-1:0]   pc_q;
  logic [XLEN-1:0]   pc_next;
  ctrl_t             ctrl;
  logic [5:0]        f_op;
  logic [5:0]        f_fn;
  logic [IDX_W-1:0]  f_rs;
  logic [IDX_W-1:0]  f_rt;
  logic [IDX_W-1:0]  f_rd;
  logic [IMM_W-1:0]  f_imm;
  logic [XLEN-1:0]   imm_ext;
  logic [XLEN-1:0]   rf_rdata_a;
  logic [XLEN-1:0]   rf_rdata_b;
  logic [IDX_W-1:0]  rf_raddr_a;
  logic              rf_we;
  logic [IDX_W-1:0]  rf_waddr;
  logic [XLEN-1:0]   rf_wdata;
  logic [XLEN-1:0]   alu_b;
  logic [XLEN-1:0]   alu_y;
  logic              alu_zero;

  assign f_op  = imem_rdata[31:26];
  assign f_rs  = IDX_W'(imem_rdata[25:21]);
  assign f_rt  = IDX_W'(imem_rdata[20:16]);
  assign f_rd  = IDX_W'(imem_rdata[15:11]);
  assign f_fn  = imem_rdata[5:0];
  assign f_imm = imem_rdata[IMM_W-1:0];

  sc_core_decode u_dec (
    .opcode (f_op),
    .funct  (f_fn),
    .ctrl   (ctrl)
  );

  assign imm_ext = ctrl.imm_zero_ext ? {{(XLEN-IMM_W){1'b0}}, f_imm}
                                     : {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm};

  assign rf_raddr_a = f_rs;
  assign rf_we      = ctrl.reg_we & ~rst;
  assign rf_waddr   = ctrl.dst_is_rd ? f_rd : f_rt;
  assign rf_wdata   = ctrl.load_to_reg ? dmem_rdata : alu_y;

  sc_core_regfile #(.DATA_W(XLEN), .NREGS(NREGS)) u_rf (
    .clk     (clk),
    .raddr_a (rf_raddr_a),
    .raddr_b (f_rt),
    .rdata_a (rf_rdata_a),
    .rdata_b (rf_rdata_b),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata)
  );

  assign alu_b = ctrl.b_from_imm ? imm_ext : rf_rdata_b;

  sc_core_alu #(.W(XLEN)) u_alu (
    .a    (rf_rdata_a),
    .b    (alu_b),
    .op   (ctrl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  sc_core_nextpc #(.W(XLEN), .IMM_W(IMM_W)) u_npc (
    .pc      (pc_q),
    .offset  (f_imm),
    .take    (ctrl.is_branch & alu_zero),
    .pc_next (pc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rf_rdata_b;
  assign dmem_we    = ctrl.mem_we & ~rst;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IDX_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [XLEN-1:0]  imem_addr,
  input logic [XLEN-1:0]  imem_rdata,
  input logic             dmem_we,
  input logic [IDX_W-1:0] rf_raddr_a,
  input logic [XLEN-1:0]  rf_rdata_a,
  input logic             rf_we
);

  // R1: reset loads PC 0
  a_r1_reset_pc: assert property (@(posedge clk) rst |=> imem_addr == '0);

  // R1: no store or register write while reset is high
  a_r1_quiet_in_reset: assert property (@(posedge clk) rst |-> (!dmem_we && !rf_we));

  // R2: anything but a branch steps the PC by 4
  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    (imem_rdata[31:26] != 6'b000100) |=> imem_addr == $past(imem_addr) + XLEN'(4));

  // R2: PC stays word aligned
  a_r2_aligned: assert property (@(posedge clk) disable iff (rst) imem_addr[1:0] == 2'b00);

  // R7: the store strobe appears only for the store opcode
  a_r7_store_only: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> imem_rdata[31:26] == 6'b101011);

  // R9: register 0 reads as zero
  a_r9_zero_reg: assert property (@(posedge clk) disable iff (rst)
    (rf_raddr_a == '0) |-> rf_rdata_a == '0);

endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .imem_addr  (imem_addr),
  .imem_rdata (imem_rdata),
  .dmem_we    (dmem_we),
  .rf_raddr_a (rf_raddr_a),
  .rf_rdata_a (rf_rdata_a),
  .rf_we      (rf_we)
);

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;

  typedef struct {
    logic [31:0] pc;
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
    string       pc_tag;
    string       mem_tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem [256];
  logic [31:0] dmem [256];
  string       note [256];
  exp_t        sb [$];
  int          n_chk = 0;
  int          n_fail = 0;
  bit          go = 1'b0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  sc_core uut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[9:2]];
  assign dmem_rdata = dmem[dmem_addr[9:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic load_program();
    for (int i = 0; i < 256; i++) begin
      imem[i] = 32'h0; dmem[i] = 32'h1000_0000 + 32'(i); note[i] = "";
    end
    dmem[15] = 32'hCAFE_BABE;
    imem[0]  = enc_i(6'b001101, 0, 1, 16'h8001);               // R5 zero-extend
    imem[1]  = enc_i(6'b001101, 0, 2, 16'h0005);
    imem[2]  = enc_r(1, 2, 3, 6'b100001);                      // R3
    imem[3]  = enc_r(2, 1, 4, 6'b100011);                      // R4 wraps
    imem[4]  = enc_i(6'b101011, 0, 3, 16'h0010); note[4] = "R3";
    imem[5]  = enc_i(6'b101011, 0, 4, 16'h0014); note[5] = "R4";
    imem[6]  = enc_i(6'b001101, 0, 5, 16'h0040);
    imem[7]  = enc_i(6'b100011, 5, 6, 16'hFFFC);               // R6 negative offset
    imem[8]  = enc_i(6'b101011, 5, 6, 16'h0000); note[8] = "R6";
    imem[9]  = enc_r(1, 2, 0, 6'b100001);                      // R9 write to r0
    imem[10] = enc_i(6'b101011, 0, 0, 16'h0018); note[10] = "R9";
    imem[11] = enc_r(1, 2, 3, 6'b100000);                      // R10 unknown funct
    imem[12] = enc_i(6'b111111, 1, 3, 16'h1234);               // R10 unknown opcode
    imem[13] = enc_i(6'b101011, 0, 3, 16'h001C); note[13] = "R10";
    imem[14] = enc_i(6'b000100, 1, 2, 16'h0005);               // R8 not taken
    imem[15] = enc_i(6'b000100, 2, 2, 16'h0002);               // R8 taken forward
    imem[16] = enc_i(6'b101011, 0, 1, 16'h0020);
    imem[17] = enc_i(6'b101011, 0, 1, 16'h0024);
    imem[18] = enc_i(6'b001101, 0, 8, 16'h0003);
    imem[19] = enc_i(6'b001101, 0, 9, 16'h0001);
    imem[20] = enc_r(8, 9, 8, 6'b100011);
    imem[21] = enc_i(6'b101011, 0, 8, 16'h0028); note[21] = "R8";
    imem[22] = enc_i(6'b000100, 8, 0, 16'h0001);
    imem[23] = enc_i(6'b000100, 0, 0, 16'hFFFC);               // R8 backward
    imem[24] = enc_i(6'b001101, 0, 10, 16'hFFFF);
    imem[25] = enc_i(6'b101011, 0, 10, 16'h002C); note[25] = "R5";
    imem[26] = enc_i(6'b000100, 0, 0, 16'hFFFF);               // spin
  endtask

  // Driver: instruction-level model pushes one expected record per cycle
  task automatic build_expected(int steps);
    logic [31:0] r [32];
    logic [31:0] m [256];
    logic [31:0] pc = 32'h0;
    bit          was_branch = 1'b0;
    for (int i = 0; i < 32; i++) r[i] = 32'h0;
    for (int i = 0; i < 256; i++) m[i] = dmem[i];
    for (int s = 0; s < steps; s++) begin
      exp_t        e;
      logic [31:0] w = imem[pc[9:2]];
      logic [5:0]  op = w[31:26];
      int          rs = int'(w[25:21]);
      int          rt = int'(w[20:16]);
      int          rd = int'(w[15:11]);
      logic [31:0] sx = {{16{w[15]}}, w[15:0]};
      logic [31:0] nx = pc + 32'd4;
      int          dst = -1;
      logic [31:0] val = 32'h0;
      e.pc = pc; e.we = 1'b0; e.addr = 32'h0; e.data = 32'h0;
      e.pc_tag = was_branch ? "R8" : "R2";
      e.mem_tag = "R10";
      was_branch = 1'b0;
      if (op == 6'b000000 && w[5:0] == 6'b100001) begin
        dst = rd; val = r[rs] + r[rt]; e.mem_tag = "R3";
      end else if (op == 6'b000000 && w[5:0] == 6'b100011) begin
        dst = rd; val = r[rs] - r[rt]; e.mem_tag = "R4";
      end else if (op == 6'b001101) begin
        dst = rt; val = r[rs] | {16'h0, w[15:0]}; e.mem_tag = "R5";
      end else if (op == 6'b100011) begin
        dst = rt; val = m[(r[rs] + sx) >> 2 & 32'hFF]; e.mem_tag = "R6";
      end else if (op == 6'b101011) begin
        e.we = 1'b1; e.addr = r[rs] + sx; e.data = r[rt];
        e.mem_tag = (note[pc[9:2]] != "") ? note[pc[9:2]] : "R7";
        m[e.addr[9:2]] = e.data;
      end else if (op == 6'b000100) begin
        was_branch = 1'b1; e.mem_tag = "R8";
        if (r[rs] == r[rt]) nx = nx + {sx[29:0], 2'b00};
      end
      if (dst > 0) r[dst] = val;
      pc = nx;
      sb.push_back(e);
    end
  endtask

  // Monitor: pop and compare one record per cycle
  initial begin
    wait (go);
    while (sb.size() > 0) begin
      exp_t e;
      #1;
      e = sb.pop_front();
      check(e.pc_tag, "imem_addr", imem_addr, e.pc);
      check(e.mem_tag, "dmem_we", 32'(dmem_we), 32'(e.we));
      if (e.we) begin
        check(e.mem_tag, "dmem_addr", dmem_addr, e.addr);
        check(e.mem_tag, "dmem_wdata", dmem_wdata, e.data);
      end
      @(negedge clk);
    end
    done = 1'b1;
  end

  initial begin
    load_program();
    build_expected(70);
    imem[30] = enc_i(6'b101011, 0, 0, 16'h0030);   // never reached after reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state, with a store on the fetch path to prove the strobe is held off
    imem[0] = enc_i(6'b101011, 0, 0, 16'h0030);
    #1;
    check("R1", "imem_addr in reset", imem_addr, 32'h0);
    check("R1", "dmem_we in reset", 32'(dmem_we), 32'h0);
    imem[0] = enc_i(6'b001101, 0, 1, 16'h8001);
    @(negedge clk);
    rst = 1'b0;
    go = 1'b1;
    wait (done);
    // R1: the store shown during reset must not have reached memory
    check("R1", "memory after reset store", dmem[12], 32'h1000_000C);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule